// File: doc/BRIEF.md
# Pipelined Justifying Pixel Read Path

This block sits between a bit-mapped frame buffer and the host bus and carries pixel data back to the host. On every read strobe it captures the frame-buffer bits at the addressed pixel into a source register and, in the same cycle, moves the value that register held before into an output data latch that drives the bus. A host read therefore always returns the pixels fetched by the read before it. Software starts a block read with one throw-away read, and each later read returns the previous fetch.

The pixel position need not fall on a word boundary. The frame-buffer side supplies the word that holds the addressed pixel and the word that follows it, plus the pixel offset inside the first word. The block rotates the pair so that the addressed pixel lands on bit 15. A width code then keeps only the top N bits and clears the rest. The source register can also be loaded from the bus on a write, with the same width trimming. Its value goes out to the rasterop unit, and a later read brings it back to the bus, which is how contents that cannot be read directly reach the host.

Top module: `pixrd_path`

## Requirements
- R1: While `rst` is high at a rising edge, `src_q` and `bus_rdata` both become 0x0000. The first read after reset therefore puts 0x0000 on `bus_rdata`.
- R2: At a rising edge with `rd_stb` high, `src_q` takes the justified, width-trimmed frame-buffer value described in R4 and R5.
- R3: At a rising edge with `rd_stb` high, `bus_rdata` takes the value `src_q` held just before that edge. The bus always shows data one read behind.
- R4: The justified value is bits 31..16 of the 32-bit word {`fb_cur`,`fb_nxt`} shifted left by `pix_ofs` (0..15). With both words at 0xF0F0 and width code 15, offset 0 gives 0xF0F0, offset 2 gives 0xC3C3 and offset 5 gives 0x1E1E.
- R5: Width code `wid_code` = c (0..15) selects N = c+1 valid pixels. Bits 15 down to 16-N keep their value and all lower bits are forced to 0. Code 0 keeps only bit 15, and code 15 keeps all 16 bits.
- R6: At a rising edge with `src_wr` high and `rd_stb` low, `src_q` takes `wr_data` trimmed as in R5, and `bus_rdata` keeps its value. A following read then returns that value on the bus.
- R7: At a rising edge with both `rd_stb` and `src_wr` low, `src_q` and `bus_rdata` keep their values.
- R8: When `rd_stb` and `src_wr` are both high at an edge, the read wins. The source register loads from the frame buffer and the latch updates as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Bus read strobe for one cycle |
| src_wr | input | 1 | Load the source register from `wr_data` |
| wr_data | input | 16 | Bus write data |
| fb_cur | input | 16 | Frame-buffer word holding the addressed pixel |
| fb_nxt | input | 16 | Frame-buffer word that follows `fb_cur` |
| pix_ofs | input | 4 | Pixel offset of the addressed pixel within `fb_cur` |
| wid_code | input | 4 | Width code, valid pixel count minus one |
| bus_rdata | output | 16 | Output data latch, high-order justified |
| src_q | output | 16 | Source register, also sent to the rasterop unit |

## Verification
The hardest case to reach is a read that overlaps a bus write to the source register in the same cycle, right after a narrow width load. Whether the latch then shows the written value or the value fetched before it depends on both the priority and the one-read delay. The stimulus mixes random reads and writes, so strobes collide often, and the width code changes on almost every cycle. Directed steps also write a known value, read it back through the one-read delay, and then use the smallest and largest width codes at the extreme offsets.

// File: rtl/pixrd_pkg.sv
package pixrd_pkg;

    localparam int PIX_W = 16;
    localparam int OFS_W = $clog2(PIX_W);

    typedef logic [PIX_W-1:0] word_t;
    typedef logic [OFS_W-1:0] ofs_t;

    // word pair covering an unaligned pixel run
    typedef struct packed {
        word_t hi;
        word_t lo;
    } span_t;

    // what the source register does this cycle
    typedef enum logic [1:0] {
        SRC_HOLD     = 2'd0,
        SRC_FROM_FB  = 2'd1,
        SRC_FROM_BUS = 2'd2
    } src_sel_e;

    typedef struct packed {
        src_sel_e sel;
        logic     lat_en;
    } step_t;

    function automatic step_t decode_step(input logic rd, input logic wr);
        step_t s;
        s.lat_en = rd;
        if (rd)      s.sel = SRC_FROM_FB;
        else if (wr) s.sel = SRC_FROM_BUS;
        else         s.sel = SRC_HOLD;
        return s;
    endfunction

endpackage

// File: rtl/pixrd_ctl.sv
module pixrd_ctl
    import pixrd_pkg::*;
(
    input  logic  rd_stb,
    input  logic  src_wr,
    output step_t step
);
    always_comb begin
        step = decode_step(rd_stb, src_wr);
    end
endmodule

// File: rtl/pixrd_justify.sv
module pixrd_justify #(
    parameter int W  = pixrd_pkg::PIX_W,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  fb_cur,
    input  logic [W-1:0]  fb_nxt,
    input  logic [SW-1:0] ofs,
    input  logic [SW-1:0] wid_code,
    output logic [W-1:0]  keep_mask,
    output logic [W-1:0]  just_word
);
    logic [2*W-1:0] stage [0:SW];

    assign stage[0] = {fb_cur, fb_nxt};

    // logarithmic shifter, one stage per offset bit
    for (genvar s = 0; s < SW; s++) begin : g_shift
        assign stage[s+1] = ofs[s] ? (stage[s] << (1 << s)) : stage[s];
    end

    // keep bit i when it lies within the top (code+1) positions
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign keep_mask[i] = ((int'(wid_code) + i) >= (W - 1));
    end

    assign just_word = stage[SW][2*W-1:W] & keep_mask;
endmodule

// File: rtl/pixrd_regs.sv
module pixrd_regs
    import pixrd_pkg::*;
#(
    parameter int W = PIX_W
) (
    input  logic         clk,
    input  logic         rst,
    input  step_t        step,
    input  logic [W-1:0] fb_val,
    input  logic [W-1:0] bus_val,
    output logic [W-1:0] src_r,
    output logic [W-1:0] lat_r
);
    always_ff @(posedge clk) begin
        if (rst) begin
            src_r <= '0;
            lat_r <= '0;
        end else begin
            if (step.lat_en) lat_r <= src_r;
            unique case (step.sel)
                SRC_FROM_FB:  src_r <= fb_val;
                SRC_FROM_BUS: src_r <= bus_val;
                default:      src_r <= src_r;
            endcase
        end
    end
endmodule

// File: rtl/pixrd_path.sv
module pixrd_path
    import pixrd_pkg::*;
#(
    parameter int W = PIX_W,
    localparam int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_stb,
    input  logic          src_wr,
    input  logic [W-1:0]  wr_data,
    input  logic [W-1:0]  fb_cur,
    input  logic [W-1:0]  fb_nxt,
    input  logic [SW-1:0] pix_ofs,
    input  logic [SW-1:0] wid_code,
    output logic [W-1:0]  bus_rdata,
    output logic [W-1:0]  src_q
);
    step_t        step;
    logic [W-1:0] keep_mask;
    logic [W-1:0] fb_just;
    logic [W-1:0] bus_trim;

    pixrd_ctl u_ctl (
        .rd_stb (rd_stb),
        .src_wr (src_wr),
        .step   (step)
    );

    pixrd_justify #(.W(W)) u_just (
        .fb_cur    (fb_cur),
        .fb_nxt    (fb_nxt),
        .ofs       (pix_ofs),
        .wid_code  (wid_code),
        .keep_mask (keep_mask),
        .just_word (fb_just)
    );

    // bus writes keep only the high-order width bits as well (R6)
    assign bus_trim = wr_data & keep_mask;

    pixrd_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .fb_val  (fb_just),
        .bus_val (bus_trim),
        .src_r   (src_q),
        .lat_r   (bus_rdata)
    );
endmodule

// File: rtl/pixrd_chk.sv
module pixrd_chk #(
    parameter int W = 16,
    localparam int SW = $clog2(W)
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_stb,
    input logic          src_wr,
    input logic [W-1:0]  wr_data,
    input logic [SW-1:0] wid_code,
    input logic [W-1:0]  bus_rdata,
    input logic [W-1:0]  src_q
);
    logic [W-1:0] chk_mask;
    logic         rst_d;

    assign chk_mask = ~({W{1'b1}} >> (int'(wid_code) + 1));

    always_ff @(posedge clk) rst_d <= rst;

    // R1
    always @(posedge clk) begin
        if (rst_d === 1'b1) begin
            reset_zero_chk: assert (bus_rdata == '0 && src_q == '0)
                else $error("reset values not zero");
        end
    end

    // R3
    latch_lag_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> bus_rdata == $past(src_q));

    // R5
    width_trim_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> (src_q & ~$past(chk_mask)) == '0);

    // R6
    bus_load_chk: assert property (@(posedge clk) disable iff (rst)
        (src_wr && !rd_stb) |=> (src_q == $past(wr_data & chk_mask)) && $stable(bus_rdata));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!src_wr && !rd_stb) |=> $stable(src_q) && $stable(bus_rdata));
endmodule

bind pixrd_path pixrd_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .rd_stb    (rd_stb),
    .src_wr    (src_wr),
    .wr_data   (wr_data),
    .wid_code  (wid_code),
    .bus_rdata (bus_rdata),
    .src_q     (src_q)
);

// File: tb/pixrd_path_tb_top.sv
module pixrd_path_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_stb = 1'b0;
    logic        src_wr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] fb_cur = '0;
    logic [15:0] fb_nxt = '0;
    logic [3:0]  pix_ofs = '0;
    logic [3:0]  wid_code = '0;
    logic [15:0] bus_rdata;
    logic [15:0] src_q;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [15:0] m_src = '0;
    logic [15:0] m_lat = '0;

    always #2 clk = ~clk;

    pixrd_path dut_i (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .src_wr(src_wr),
        .wr_data(wr_data), .fb_cur(fb_cur), .fb_nxt(fb_nxt),
        .pix_ofs(pix_ofs), .wid_code(wid_code),
        .bus_rdata(bus_rdata), .src_q(src_q)
    );

    function automatic logic [15:0] ref_mask(input logic [3:0] c);
        logic [15:0] m = '0;
        for (int i = 0; i <= int'(c); i++) m[15-i] = 1'b1;
        return m;
    endfunction

    function automatic logic [15:0] ref_just(input logic [15:0] a, input logic [15:0] b,
                                             input logic [3:0] o, input logic [3:0] c);
        logic [31:0] pair = {a, b};
        logic [31:0] sh = pair << o;
        return sh[31:16] & ref_mask(c);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic rd, input logic wr, input logic [15:0] wd,
                        input logic [15:0] a, input logic [15:0] b,
                        input logic [3:0] o, input logic [3:0] c, input string tag);
        @(negedge clk);
        rd_stb = rd; src_wr = wr; wr_data = wd;
        fb_cur = a; fb_nxt = b; pix_ofs = o; wid_code = c;
        @(posedge clk);
        #1;
        if (rd) begin
            m_lat = m_src;
            m_src = ref_just(a, b, o, c);
        end else if (wr) begin
            m_src = wd & ref_mask(c);
        end
        chk({tag, " src"}, src_q, m_src);
        chk({tag, " bus"}, bus_rdata, m_lat);
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        if (!done) begin
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset src", src_q, 16'h0000);
        chk("R1 reset bus", bus_rdata, 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        // R1 first read returns zero; R4 aligned read
        step(1, 0, 16'h0, 16'hF0F0, 16'hF0F0, 4'd0, 4'd15, "R1/R4 off0");
        chk("R4 off0 src F0F0", src_q, 16'hF0F0);
        step(1, 0, 16'h0, 16'hF0F0, 16'hF0F0, 4'd2, 4'd15, "R3/R4 off2");
        chk("R4 off2 src C3C3", src_q, 16'hC3C3);
        chk("R3 bus lag F0F0", bus_rdata, 16'hF0F0);
        step(1, 0, 16'h0, 16'hF0F0, 16'hF0F0, 4'd5, 4'd15, "R4 off5");
        chk("R4 off5 src 1E1E", src_q, 16'h1E1E);
        chk("R3 bus lag C3C3", bus_rdata, 16'hC3C3);
        // R5 width code 0 and offset 15
        step(1, 0, 16'h0, 16'h0001, 16'hFFFF, 4'd15, 4'd0, "R5 narrow");
        chk("R5 only bit15", src_q, 16'h8000);
        step(1, 0, 16'h0, 16'h0001, 16'h2AAA, 4'd15, 4'd15, "R4 off15");
        chk("R4 off15 src", src_q, 16'h9555);
        // R6 write then readback; R7 idle
        step(0, 1, 16'hBEEF, 16'h1234, 16'h5678, 4'd3, 4'd7, "R6 write");
        chk("R6 trimmed write", src_q, 16'hBE00);
        step(0, 0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 4'd1, 4'd15, "R7 idle");
        step(1, 0, 16'h0, 16'h0F0F, 16'h0000, 4'd4, 4'd15, "R6 readback");
        chk("R6 readback on bus", bus_rdata, 16'hBE00);
        // R8 collision
        step(1, 1, 16'hAAAA, 16'h1357, 16'h9BDF, 4'd6, 4'd11, "R8 both");
        step(1, 1, 16'h5555, 16'h0000, 16'h0000, 4'd0, 4'd15, "R8 both2");
        chk("R8 read wins", src_q, 16'h0000);

        for (int k = 0; k < 400; k++) begin
            logic [1:0] op = 2'($urandom_range(0, 3));
            step(op[0], op[1], 16'($urandom), 16'($urandom), 16'($urandom),
                 4'($urandom), 4'($urandom), "R2/R3/R5/R6/R7/R8 random");
        end

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1; rd_stb = 1'b0; src_wr = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 re-reset src", src_q, 16'h0000);
        chk("R1 re-reset bus", bus_rdata, 16'h0000);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule